// File: doc/BRIEF.md
# Dual-Channel ADC Offset Calibration Sequencer

This block is the digital framing, calibration and correction logic for a two-channel 12-bit serial converter. It watches an active-low chip-select and a serial clock, both already synchronous to the system clock. A frame opens on a chip-select falling edge and completes on the 19th serial-clock rising edge that follows. When a frame completes, the raw codes of both channels are taken from parallel inputs.

Each frame is either a calibration frame or a normal frame. This is decided at the chip-select falling edge from two sources: a level calibrate input and a one-shot software calibrate bit. In a calibration frame the inputs of the converter are shorted outside this block. The block then stores, per channel, the difference between the raw code and mid-scale as a signed offset. In a normal frame the stored offset is subtracted from each raw code and the result is presented with a one-cycle valid pulse.

A calibrate request that arrives while a frame is in progress marks that frame's result as corrupted. The block keeps the gain setting that was in force at the last calibration and raises a stale flag while the current gain differs from it.

Top module: `adc_offset_cal`

## Requirements
- R1: After reset, both offset readbacks are 0, `stale` and `cal_bit` are 0, and `out_valid`, `cal_done` and `out_corrupt` are 0.
- R2: A frame completes on the 19th rising edge of `sclk` counted after a falling edge of `csn`. It gives exactly one result pulse (`out_valid` or `cal_done`) in the clock cycle after that edge. Further `sclk` edges before `csn` rises are ignored.
- R3: If `csn` rises before 19 `sclk` edges, the frame is discarded: no result pulse, and no change to either offset.
- R4: A frame whose `csn` falling edge sees `cal_pin` high or `cal_bit` set is a calibration frame. At completion it pulses `cal_done` but not `out_valid`, and it stores raw − 2048 as each channel's signed offset.
- R5: A measured offset beyond ±128 is clamped to +128 or −128. Offset readbacks are 9-bit two's complement.
- R6: A normal frame pulses `out_valid` and presents raw − offset per channel, saturated to the range 0..4095. Between results, `out_a` and `out_b` hold their last values.
- R7: While `cal_pin` stays high, every frame is a calibration frame and refreshes both offsets.
- R8: A rising edge of `cal_pin` while a frame is open and fewer than 19 `sclk` edges have been counted sets `out_corrupt` with that frame's result pulse. The frame keeps the type it was given at its start.
- R9: A `sw_cal_wr` pulse sets `cal_bit`. The next frame is then a calibration frame, and `cal_bit` clears at that frame's `csn` falling edge. A pulse that arrives in an open frame with fewer than 19 edges counted also marks that frame corrupted.
- R10: `stale` is 1 when at least one calibration has completed and the `gain` input differs from its value at the start of the last completed calibration frame. It is 0 otherwise.
- R11: The first `csn` falling edge after `cal_pin` returns low, with `cal_bit` clear, starts a normal frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csn | input | 1 | Chip-select, active low, synchronous to clk |
| sclk | input | 1 | Serial clock level, synchronous to clk |
| cal_pin | input | 1 | Level calibrate request |
| sw_cal_wr | input | 1 | One-cycle write of the software calibrate bit |
| gain | input | 3 | Current amplifier gain setting |
| raw_a | input | 12 | Raw code of channel A, valid at frame completion |
| raw_b | input | 12 | Raw code of channel B, valid at frame completion |
| out_a | output | 12 | Corrected code of channel A |
| out_b | output | 12 | Corrected code of channel B |
| out_valid | output | 1 | One-cycle pulse: normal result ready |
| cal_done | output | 1 | One-cycle pulse: calibration stored |
| out_corrupt | output | 1 | Accompanies a result pulse whose frame was disturbed |
| offs_a | output | 9 | Stored offset of channel A, signed |
| offs_b | output | 9 | Stored offset of channel B, signed |
| cal_bit | output | 1 | Readback of the pending software calibrate bit |
| stale | output | 1 | Offsets belong to a different gain setting |

## Verification
The hardest situations to reach are the requests that land inside an open frame. A calibrate edge or a software write has to arrive after some serial clocks have been counted but before the 19th, and the disturbed frame must keep its own type while the next frame changes type. The bench places each such event at a chosen serial-clock index inside the frame. It then runs the following frame with the request still pending, so both the corrupt flag and the change of frame type are observed. Frames aborted after 12 clocks and frames stretched to 25 clocks cover the boundaries of the 19-clock count.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

    localparam int CODE_W     = 12;
    localparam int OFS_W      = 9;
    localparam int OFS_LIM    = 128;
    localparam int GAIN_W     = 3;
    localparam int CH_N       = 2;
    localparam int FRAME_CLKS = 19;
    localparam int CODE_MAX   = (1 << CODE_W) - 1;
    localparam int ZERO_CODE  = 1 << (CODE_W - 1);

    typedef logic [CODE_W-1:0]        code_t;
    typedef logic signed [OFS_W-1:0]  ofs_t;
    typedef logic [GAIN_W-1:0]        gain_t;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_RUN  = 2'd1,
        FR_HOLD = 2'd2
    } fr_state_e;

    typedef struct packed {
        logic  is_cal;
        logic  corrupt;
        gain_t gain;
    } frame_info_t;

    function automatic ofs_t meas_offset(code_t raw);
        int d;
        d = int'(raw) - ZERO_CODE;
        if (d > OFS_LIM)  d = OFS_LIM;
        if (d < -OFS_LIM) d = -OFS_LIM;
        return ofs_t'(d);
    endfunction

    function automatic code_t apply_offset(code_t raw, ofs_t ofs);
        int s;
        s = int'(raw) - int'(ofs);
        if (s < 0)        s = 0;
        if (s > CODE_MAX) s = CODE_MAX;
        return code_t'(s);
    endfunction

endpackage

// File: rtl/adc_frame_tracker.sv
module adc_frame_tracker
    import adc_cal_pkg::*;
#(
    parameter int NCLK = FRAME_CLKS
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        csn,
    input  logic        sclk,
    input  logic        cal_pin,
    input  logic        sw_cal_wr,
    input  gain_t       gain,
    output logic        fin,
    output frame_info_t info_o,
    output logic        corrupt_o,
    output logic        cal_bit
);

    localparam int CNT_W = $clog2(NCLK + 1);

    fr_state_e    st;
    logic [CNT_W-1:0] cnt;
    logic         csn_q, sclk_q, cal_q;
    frame_info_t  info;

    logic cs_fall, sclk_rise, cal_rise, disturb;

    always_comb begin
        cs_fall   = csn_q & ~csn;
        sclk_rise = sclk & ~sclk_q;
        cal_rise  = cal_pin & ~cal_q;
        disturb   = (st == FR_RUN) & (cal_rise | sw_cal_wr);
        fin       = (st == FR_RUN) & ~csn & sclk_rise &
                    (cnt == CNT_W'(NCLK - 1));
        info_o    = info;
        corrupt_o = info.corrupt | disturb;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= FR_IDLE;
            cnt     <= '0;
            csn_q   <= 1'b1;
            sclk_q  <= 1'b0;
            cal_q   <= 1'b0;
            info    <= '0;
            cal_bit <= 1'b0;
        end else begin
            csn_q  <= csn;
            sclk_q <= sclk;
            cal_q  <= cal_pin;

            if (sw_cal_wr)
                cal_bit <= 1'b1;
            else if (cs_fall && st == FR_IDLE)
                cal_bit <= 1'b0;

            unique case (st)
                FR_IDLE: begin
                    if (cs_fall) begin
                        st           <= FR_RUN;
                        cnt          <= '0;
                        info.is_cal  <= cal_pin | cal_bit;
                        info.corrupt <= sw_cal_wr;
                        info.gain    <= gain;
                    end
                end
                FR_RUN: begin
                    if (csn) begin
                        st <= FR_IDLE;
                    end else begin
                        if (sclk_rise) cnt <= cnt + 1'b1;
                        if (disturb)   info.corrupt <= 1'b1;
                        if (fin)       st <= FR_HOLD;
                    end
                end
                FR_HOLD: begin
                    if (csn) st <= FR_IDLE;
                end
                default: st <= FR_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/adc_chan_slice.sv
module adc_chan_slice
    import adc_cal_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  store,
    input  code_t raw,
    output ofs_t  ofs,
    output code_t corr
);

    always_ff @(posedge clk) begin
        if (rst)
            ofs <= '0;
        else if (store)
            ofs <= meas_offset(raw);
    end

    always_comb corr = apply_offset(raw, ofs);

endmodule

// File: rtl/adc_offset_cal.sv
module adc_offset_cal
    import adc_cal_pkg::*;
#(
    parameter int NCLK = FRAME_CLKS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csn,
    input  logic              sclk,
    input  logic              cal_pin,
    input  logic              sw_cal_wr,
    input  logic [GAIN_W-1:0] gain,
    input  logic [CODE_W-1:0] raw_a,
    input  logic [CODE_W-1:0] raw_b,
    output logic [CODE_W-1:0] out_a,
    output logic [CODE_W-1:0] out_b,
    output logic              out_valid,
    output logic              cal_done,
    output logic              out_corrupt,
    output logic [OFS_W-1:0]  offs_a,
    output logic [OFS_W-1:0]  offs_b,
    output logic              cal_bit,
    output logic              stale
);

    logic        fin, corrupt_now;
    frame_info_t info;
    code_t       raw_v  [CH_N];
    code_t       corr_v [CH_N];
    ofs_t        ofs_v  [CH_N];
    code_t       res_v  [CH_N];
    logic        have_cal;
    gain_t       cal_gain;

    adc_frame_tracker #(.NCLK(NCLK)) u_track (
        .clk       (clk),
        .rst       (rst),
        .csn       (csn),
        .sclk      (sclk),
        .cal_pin   (cal_pin),
        .sw_cal_wr (sw_cal_wr),
        .gain      (gain),
        .fin       (fin),
        .info_o    (info),
        .corrupt_o (corrupt_now),
        .cal_bit   (cal_bit)
    );

    assign raw_v[0] = raw_a;
    assign raw_v[1] = raw_b;

    for (genvar g = 0; g < CH_N; g++) begin : g_ch
        adc_chan_slice u_ch (
            .clk   (clk),
            .rst   (rst),
            .store (fin & info.is_cal),
            .raw   (raw_v[g]),
            .ofs   (ofs_v[g]),
            .corr  (corr_v[g])
        );

        always_ff @(posedge clk) begin
            if (rst)
                res_v[g] <= '0;
            else if (fin && !info.is_cal)
                res_v[g] <= corr_v[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            cal_done    <= 1'b0;
            out_corrupt <= 1'b0;
            have_cal    <= 1'b0;
            cal_gain    <= '0;
        end else begin
            out_valid   <= fin & ~info.is_cal;
            cal_done    <= fin &  info.is_cal;
            out_corrupt <= fin &  corrupt_now;
            if (fin && info.is_cal) begin
                have_cal <= 1'b1;
                cal_gain <= info.gain;
            end
        end
    end

    assign out_a  = res_v[0];
    assign out_b  = res_v[1];
    assign offs_a = ofs_v[0];
    assign offs_b = ofs_v[1];
    assign stale  = have_cal & (gain != cal_gain);

endmodule

// File: rtl/adc_offset_cal_chk.sv
module adc_offset_cal_chk
    import adc_cal_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              csn,
    input logic [GAIN_W-1:0] gain,
    input logic              out_valid,
    input logic              cal_done,
    input logic [OFS_W-1:0]  offs_a,
    input logic [OFS_W-1:0]  offs_b,
    input logic              cal_bit,
    input logic              stale
);

    logic csn_prev;
    always_ff @(posedge clk) begin
        if (rst) csn_prev <= 1'b1;
        else     csn_prev <= csn;
    end

    // R2: a result pulse lasts one cycle
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (out_valid || cal_done) |=> !(out_valid || cal_done));

    // R4: a frame is either a calibration or a normal result, never both
    a_r4_one_kind: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && cal_done));

    // R4: offsets move only together with a calibration pulse
    a_r4_offs_only_on_cal: assert property (@(posedge clk) disable iff (rst)
        (!$stable(offs_a) || !$stable(offs_b)) |-> cal_done);

    // R5: stored offsets stay inside the clamp limits
    a_r5_offs_range: assert property (@(posedge clk) disable iff (rst)
        ($signed(offs_a) >= -OFS_LIM) && ($signed(offs_a) <= OFS_LIM) &&
        ($signed(offs_b) >= -OFS_LIM) && ($signed(offs_b) <= OFS_LIM));

    // R9: the software bit clears only on a chip-select falling edge
    a_r9_bit_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(cal_bit) |-> ($past(csn_prev) && !$past(csn)));

    // R10: stale rises only on a gain change or a finished calibration
    a_r10_stale_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(stale) |-> (!$stable(gain) || cal_done));

endmodule

bind adc_offset_cal adc_offset_cal_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .csn       (csn),
    .gain      (gain),
    .out_valid (out_valid),
    .cal_done  (cal_done),
    .offs_a    (offs_a),
    .offs_b    (offs_b),
    .cal_bit   (cal_bit),
    .stale     (stale)
);

// File: tb/sim_adc_offset_cal.sv
module sim_adc_offset_cal;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csn = 1'b1;
    logic        sclk = 1'b0;
    logic        cal_pin = 1'b0;
    logic        sw_cal_wr = 1'b0;
    logic [2:0]  gain = 3'd0;
    logic [11:0] raw_a = '0;
    logic [11:0] raw_b = '0;
    logic [11:0] out_a, out_b;
    logic        out_valid, cal_done, out_corrupt;
    logic [8:0]  offs_a, offs_b;
    logic        cal_bit, stale;

    always #5 clk = ~clk;

    adc_offset_cal u0 (
        .clk(clk), .rst(rst), .csn(csn), .sclk(sclk), .cal_pin(cal_pin),
        .sw_cal_wr(sw_cal_wr), .gain(gain), .raw_a(raw_a), .raw_b(raw_b),
        .out_a(out_a), .out_b(out_b), .out_valid(out_valid),
        .cal_done(cal_done), .out_corrupt(out_corrupt), .offs_a(offs_a),
        .offs_b(offs_b), .cal_bit(cal_bit), .stale(stale)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_oa = 0, m_ob = 0;
    bit m_pend = 0;
    bit m_have = 0;
    int m_gain = 0;

    int nv, nc, ncor, cap_a, cap_b;

    function automatic int exp_ofs(int raw);
        int d = raw - 2048;
        if (d > 128)  d = 128;
        if (d < -128) d = -128;
        return d;
    endfunction

    function automatic int exp_out(int raw, int ofs);
        int s = raw - ofs;
        if (s < 0)    s = 0;
        if (s > 4095) s = 4095;
        return s;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic sample();
        if (out_valid) begin
            nv++;
            cap_a = int'(out_a);
            cap_b = int'(out_b);
        end
        if (cal_done)    nc++;
        if (out_corrupt) ncor++;
    endtask

    task automatic step();
        @(negedge clk);
        sample();
    endtask

    // ev_kind 0: cal_pin rises before serial clock ev_at; 1: software write
    task automatic run_frame(input bit calp, input int ra, input int rb,
                             input int nclk, input int ev_at, input int ev_kind,
                             input string tag);
        bit exp_cal, complete, ev_in, ev_done;
        nv = 0; nc = 0; ncor = 0; cap_a = -1; cap_b = -1;
        ev_done = 0;
        raw_a = 12'(ra); raw_b = 12'(rb); cal_pin = calp;
        step();
        exp_cal = calp | m_pend;
        m_pend  = 0;
        csn = 1'b0;
        step();
        for (int i = 0; i < nclk; i++) begin
            if (i == ev_at) begin
                ev_done = 1;
                if (ev_kind == 0) begin
                    cal_pin = 1'b1;
                end else begin
                    sw_cal_wr = 1'b1;
                    step();
                    sw_cal_wr = 1'b0;
                    m_pend = 1;
                end
            end
            sclk = 1'b1; step();
            sclk = 1'b0; step();
        end
        csn = 1'b1;
        step();
        step();
        complete = (nclk >= 19);
        ev_in    = ev_done && (ev_at < 19);
        if (complete) begin
            if (exp_cal) begin
                chk(nc == 1 && nv == 0, tag, "calibration pulse count", nc, 1);
                m_oa = exp_ofs(ra);
                m_ob = exp_ofs(rb);
                m_have = 1;
                m_gain = int'(gain);
            end else begin
                chk(nv == 1 && nc == 0, tag, "result pulse count", nv, 1);
                chk(cap_a == exp_out(ra, m_oa), tag, "out_a", cap_a, exp_out(ra, m_oa));
                chk(cap_b == exp_out(rb, m_ob), tag, "out_b", cap_b, exp_out(rb, m_ob));
            end
            chk(ncor == (ev_in ? 1 : 0), tag, "corrupt flag", ncor, ev_in ? 1 : 0);
        end else begin
            chk(nv + nc == 0, tag, "aborted frame pulses", nv + nc, 0);
        end
        chk($signed(offs_a) == m_oa, tag, "offs_a", $signed(offs_a), m_oa);
        chk($signed(offs_b) == m_ob, tag, "offs_b", $signed(offs_b), m_ob);
        chk(cal_bit == m_pend, tag, "cal_bit", int'(cal_bit), int'(m_pend));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog: actual hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(offs_a == 0 && offs_b == 0, "R1", "offsets", int'(offs_a), 0);
        chk(stale == 0 && cal_bit == 0, "R1", "stale/cal_bit", int'(stale) + int'(cal_bit), 0);
        chk(!out_valid && !cal_done && !out_corrupt, "R1", "pulses", int'(out_valid), 0);

        // R6 before any calibration offsets are zero
        run_frame(0, 1000, 3000, 19, -1, 0, "R6");

        // R4 R5 R7 consecutive calibrations with the pin held high
        for (int k = -160; k <= 160; k += 20)
            run_frame(1, 2048 + k, 2048 - k, 19, -1, 0, "R7");
        run_frame(1, 2048 + 37, 2048 - 90, 19, -1, 0, "R4");

        // R11 first frame after pin low is normal; R6 sweep with saturation
        for (int v = 0; v <= 4095; v += 91)
            run_frame(0, v, 4095 - v, 19, -1, 0, "R11");
        run_frame(0, 4095, 0, 19, -1, 0, "R6");
        run_frame(0, 20, 4040, 19, -1, 0, "R6");

        // R5 clamp at both limits
        run_frame(1, 2048 + 500, 0, 19, -1, 0, "R5");
        run_frame(0, 100, 4000, 19, -1, 0, "R5");

        // R3 aborted frames
        run_frame(1, 2048 + 3, 2048 + 4, 12, -1, 0, "R3");
        run_frame(0, 500, 500, 18, -1, 0, "R3");

        // R2 extra serial clocks ignored
        run_frame(0, 700, 800, 25, -1, 0, "R2");

        // R8 pin rises mid frame; next frame calibrates
        run_frame(0, 900, 1900, 19, 5, 0, "R8");
        run_frame(1, 2048 - 11, 2048 + 12, 19, -1, 0, "R8");
        run_frame(0, 1500, 1600, 19, -1, 0, "R11");
        // R8 rise after the 19th clock does not corrupt
        run_frame(0, 1500, 1600, 22, 20, 0, "R8");
        run_frame(0, 2000, 2100, 19, -1, 0, "R11");

        // R9 software bit while idle
        sw_cal_wr = 1'b1; @(negedge clk); sw_cal_wr = 1'b0; @(negedge clk);
        m_pend = 1;
        chk(cal_bit == 1, "R9", "cal_bit set", int'(cal_bit), 1);
        run_frame(0, 2048 + 60, 2048 - 60, 19, -1, 0, "R9");
        // R9 software write inside a frame
        run_frame(0, 1234, 2345, 19, 7, 1, "R9");
        run_frame(0, 2048 + 5, 2048 - 6, 19, -1, 0, "R9");
        run_frame(0, 3000, 100, 19, -1, 0, "R9");

        // R10 stale tracking
        chk(stale == 0, "R10", "stale after cal at same gain", int'(stale), 0);
        gain = 3'd3; @(negedge clk);
        chk(stale == 1, "R10", "stale after gain change", int'(stale), 1);
        run_frame(0, 2500, 1500, 19, -1, 0, "R10");
        chk(stale == 1, "R10", "stale kept by normal frame", int'(stale), 1);
        run_frame(1, 2048 + 9, 2048 - 9, 19, -1, 0, "R10");
        chk(stale == 0, "R10", "stale cleared by recalibration", int'(stale), 0);
        gain = 3'd5; @(negedge clk);
        chk(stale == (m_have && m_gain != 5), "R10", "stale new gain", int'(stale), 1);
        gain = 3'd3; @(negedge clk);
        chk(stale == 0, "R10", "stale back to cal gain", int'(stale), 0);
        run_frame(0, 3333, 777, 19, -1, 0, "R10");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule